// File: doc/BRIEF.md
# Ping-Pong DMA Channel

One peripheral DMA channel moves data between a device and memory in fixed-size units. It works from two alternating buffer descriptors, A and B, so software can refill one while the other is being consumed. Each descriptor is a current address and an end address. The end address is the address of the last unit of that buffer. The channel issues one memory request for each unit the device asks for and advances the current address after every acknowledged unit. When it acknowledges the last unit of a buffer, it hands over to the other buffer.

Software works the channel through a six-entry register window. An interrupt line tells it that a buffer is free and needs refilling. A stop flag in an end register marks the final buffer of a chain. When that buffer completes, the channel stays where it is and goes idle.

The status register lets the interrupt handler decide which buffer to reload:
- With INT set and OVER clear, the free buffer is the one CHAN does not select.
- With both INT and OVER set, the buffer to reload is the one CHAN selects.

Top module: `ppdma_channel`

## Requirements
- R1: After reset, mem_req and irq are low and the status register reads 3'b010. Status bit 0 is INT, bit 1 is OVER and bit 2 is CHAN (0 selects A, 1 selects B).
- R2: Register indices on reg_wr_addr and reg_rd_addr are 0 current A, 1 end A, 2 current B, 3 end B, 4 control and 5 status. Addresses sit in bits [ADDR_W-1:0], and the stop flag of an end register sits in bit 31. Control bit 0 is ENABLE, bit 1 is DIR, bit 2 is CLEAR and bits [4:3] are the size code. Every field reads back as written, except that CLEAR always reads 0.
- R3: A memory request starts in an idle cycle only when all of the following hold: the channel is enabled, the selected buffer is valid, the channel is not stopped, and dev_req is high. mem_req then rises on the next cycle and stays high until the cycle in which mem_ack is high. mem_wr equals the DIR bit (1 means device to memory).
- R4: mem_addr carries the selected buffer's current address during a request. Each acknowledged unit that is not the last one advances that address by 1 << size code bytes.
- R5: An acknowledged unit whose address equals the end address invalidates that buffer. It also toggles CHAN, unless that buffer's stop flag is set.
- R6: Completing a buffer whose stop flag is set stops the channel. CHAN keeps its value, no further request is issued even after a buffer is reloaded, and status shows OVER=1 and INT=0 until the next CLEAR.
- R7: INT, and the irq output that mirrors it, is high exactly when the channel is enabled, not stopped, and at least one buffer is invalid.
- R8: OVER is high when any of these holds: the channel is disabled, the selected buffer is invalid, or the channel is stopped. No request is started while OVER is high.
- R9: A control write with CLEAR set invalidates both buffers, sets CHAN to A, leaves the stopped state and drops any pending request on the next cycle. The other control fields take the written values.
- R10: Writing control with ENABLE=0 blocks new requests. A request already pending still completes on its acknowledge.
- R11: Writing an end register marks that buffer valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register index for reads |
| reg_rdata | output | 32 | Read data (combinational) |
| dev_req | input | 1 | Device asks for one unit |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the unit |
| mem_wr | output | 1 | 1 = write memory (device to memory) |
| mem_ack | input | 1 | Memory accepts the pending unit |
| irq | output | 1 | A buffer is free to refill |

## Verification
The assertions run on every cycle and check the following:
- A pending request keeps its address until it is acknowledged.
- A request only exists while its buffer is valid.
- A request never starts from an OVER state.
- CHAN only moves on a last-unit acknowledge or a CLEAR.
- At most one descriptor advances per cycle.
- Writing an end register validates that buffer, and consuming its last unit invalidates it.

The bench scenarios are needed for the behaviour that spans many cycles:
- the full A, B, A' chain ending on a stop flag, and the channel staying silent afterwards;
- the interrupt and status values seen between refills;
- a CLEAR that lands in the middle of a request;
- a disable that lets a pending unit finish.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam int REG_W    = 32;
  localparam int STOP_BIT = 31;
  localparam int SIZE_W   = 2;
  localparam int CTL_W    = 5;
  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_CLR  = 2;
  localparam int CTL_SZ   = 3;
  localparam int ST_INT   = 0;
  localparam int ST_OVER  = 1;
  localparam int ST_CHAN  = 2;

  localparam logic [2:0] IDX_CUR_A = 3'd0;
  localparam logic [2:0] IDX_END_A = 3'd1;
  localparam logic [2:0] IDX_CUR_B = 3'd2;
  localparam logic [2:0] IDX_END_B = 3'd3;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam logic [2:0] IDX_STAT  = 3'd5;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              dir;
    logic              en;
  } chan_cfg_t;

  // Byte step for one transfer unit.
  function automatic logic [REG_W-1:0] unit_step(input logic [SIZE_W-1:0] code);
    unit_step = REG_W'(1) << code;
  endfunction

  // Control readback: CLEAR never reads back as set.
  function automatic logic [REG_W-1:0] cfg_word(input chan_cfg_t c);
    cfg_word = '0;
    cfg_word[CTL_EN]  = c.en;
    cfg_word[CTL_DIR] = c.dir;
    cfg_word[CTL_SZ +: SIZE_W] = c.size;
  endfunction
endpackage

// File: rtl/ppdma_ctrl.sv
module ppdma_ctrl
  import ppdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output chan_cfg_t        cfg,
  output logic             clr
);
  assign clr = wr && wdata[CTL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.en   <= wdata[CTL_EN];
      cfg.dir  <= wdata[CTL_DIR];
      cfg.size <= wdata[CTL_SZ +: SIZE_W];
    end
  end
endmodule

// File: rtl/ppdma_desc.sv
module ppdma_desc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_cur,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wstop,
  input  logic              adv,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] end_o,
  output logic              stop_o,
  output logic              valid_o,
  output logic              last_o
);
  assign last_o = (cur_o == end_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_o   <= '0;
      end_o   <= '0;
      stop_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (wr_cur)             cur_o <= waddr;
      else if (adv && !last_o) cur_o <= cur_o + step;
      if (wr_end) begin
        end_o  <= waddr;
        stop_o <= wstop;
      end
      if (clr)                valid_o <= 1'b0;
      else if (wr_end)        valid_o <= 1'b1;
      else if (adv && last_o) valid_o <= 1'b0;
    end
  end

  // R11: writing the end register validates the buffer
  assert_end_validates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end && !clr |=> valid_o);
  // R5: consuming the last unit frees the buffer
  assert_last_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && last_o && !wr_end && !clr |=> !valid_o);
  // R3: units are only taken from a valid buffer
  assert_adv_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> valid_o);
endmodule

// File: rtl/ppdma_seq.sv
module ppdma_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       clr,
  input  logic       dev_req,
  input  logic       mem_ack,
  input  logic [1:0] valid,
  input  logic [1:0] stop,
  input  logic [1:0] last,
  output logic       chan,
  output logic       busy,
  output logic       stopped,
  output logic [1:0] adv
);
  logic start, done, done_last;

  assign start     = !busy && enable && valid[chan] && !stopped && dev_req;
  assign done      = busy && mem_ack;
  assign done_last = done && last[chan];
  assign adv       = done ? (chan ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      chan    <= 1'b0;
      stopped <= 1'b0;
    end else if (clr) begin
      busy    <= 1'b0;
      chan    <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done_last) begin
        if (stop[chan]) stopped <= 1'b1;
        else            chan    <= ~chan;
      end
    end
  end

  // R3: a pending request is held until acknowledged
  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ack && !clr |=> busy);
  // R3: a pending request always belongs to a valid buffer
  assert_busy_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> valid[chan]);
  // R5: the buffer select moves only on a last-unit acknowledge or CLEAR
  assert_chan_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan) |-> $past(clr || (busy && mem_ack && last[chan])));
  // R6: once stopped, nothing new starts
  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !clr |=> !busy);
  // R4: at most one descriptor advances per cycle
  assert_adv_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adv));
endmodule

// File: rtl/ppdma_channel.sv
module ppdma_channel
  import ppdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [2:0]        reg_rd_addr,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              dev_req,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  input  logic              mem_ack,
  output logic              irq
);
  chan_cfg_t         cfg;
  logic              clr;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] cur_q [2];
  logic [ADDR_W-1:0] end_q [2];
  logic [1:0]        stop_q, valid_q, last_q, adv;
  logic              chan, busy, stopped;
  logic              over_w, int_w;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[STOP_BIT-1:ADDR_W];

  ppdma_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr_en && reg_wr_addr == IDX_CTRL),
    .wdata (reg_wdata[CTL_W-1:0]),
    .cfg   (cfg),
    .clr   (clr)
  );

  assign step = ADDR_W'(unit_step(cfg.size));

  for (genvar g = 0; g < 2; g++) begin : g_desc
    ppdma_desc #(.ADDR_W(ADDR_W)) u_desc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_cur  (reg_wr_en && reg_wr_addr == 3'(2*g)),
      .wr_end  (reg_wr_en && reg_wr_addr == 3'(2*g+1)),
      .waddr   (reg_wdata[ADDR_W-1:0]),
      .wstop   (reg_wdata[STOP_BIT]),
      .adv     (adv[g]),
      .step    (step),
      .cur_o   (cur_q[g]),
      .end_o   (end_q[g]),
      .stop_o  (stop_q[g]),
      .valid_o (valid_q[g]),
      .last_o  (last_q[g])
    );
  end

  ppdma_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (cfg.en),
    .clr     (clr),
    .dev_req (dev_req),
    .mem_ack (mem_ack),
    .valid   (valid_q),
    .stop    (stop_q),
    .last    (last_q),
    .chan    (chan),
    .busy    (busy),
    .stopped (stopped),
    .adv     (adv)
  );

  assign over_w   = !cfg.en || !valid_q[chan] || stopped;
  assign int_w    = cfg.en && !stopped && !(&valid_q);
  assign irq      = int_w;
  assign mem_req  = busy;
  assign mem_addr = busy ? cur_q[chan] : '0;
  assign mem_wr   = cfg.dir;

  always_comb begin
    reg_rdata = '0;
    case (reg_rd_addr)
      IDX_CUR_A: reg_rdata[ADDR_W-1:0] = cur_q[0];
      IDX_CUR_B: reg_rdata[ADDR_W-1:0] = cur_q[1];
      IDX_END_A: begin
        reg_rdata[ADDR_W-1:0] = end_q[0];
        reg_rdata[STOP_BIT]   = stop_q[0];
      end
      IDX_END_B: begin
        reg_rdata[ADDR_W-1:0] = end_q[1];
        reg_rdata[STOP_BIT]   = stop_q[1];
      end
      IDX_CTRL: reg_rdata = cfg_word(cfg);
      IDX_STAT: begin
        reg_rdata[ST_INT]  = int_w;
        reg_rdata[ST_OVER] = over_w;
        reg_rdata[ST_CHAN] = chan;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R3: the request address holds while waiting for the acknowledge
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_wr_en |=> $stable(mem_addr));
  // R8: a request never rises out of an OVER state
  assert_no_req_over_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(!over_w));
endmodule

// File: tb/tb_ppdma_channel.sv
module tb_ppdma_channel;
  localparam int CLK_NS = 10;
  localparam int AW     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_wr_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [2:0] reg_rd_addr = 3'd5;
  logic [31:0] reg_rdata;
  logic dev_req = 1'b0;
  logic mem_req, mem_wr, irq;
  logic mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;

  // behavioural reference state
  logic [AW-1:0] m_cur [2];
  logic [AW-1:0] m_end [2];
  bit m_stop [2];
  bit m_valid [2];
  bit m_chan, m_busy, m_stopped, m_en, m_dir;
  logic [1:0] m_sz;

  always #(CLK_NS/2) clk = ~clk;

  ppdma_channel #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .dev_req(dev_req), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_ack(mem_ack), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output with the reference after each edge.
  task automatic compare();
    bit exp_int, exp_over;
    exp_int  = m_en && !m_stopped && !(m_valid[0] && m_valid[1]);
    exp_over = !m_en || !m_valid[m_chan] || m_stopped;
    chk("R3 mem_req", 32'(mem_req), 32'(m_busy));
    if (m_busy) chk("R4 mem_addr", 32'(mem_addr), 32'(m_cur[m_chan]));
    chk("R3 mem_wr", 32'(mem_wr), 32'(m_dir));
    chk("R7 irq", 32'(irq), 32'(exp_int));
    chk("R7 status INT", 32'(reg_rdata[0]), 32'(exp_int));
    chk("R8 status OVER", 32'(reg_rdata[1]), 32'(exp_over));
    chk("R5 status CHAN", 32'(reg_rdata[2]), 32'(m_chan));
  endtask

  // Drive one cycle, step the reference across the edge, then compare.
  task automatic cyc(input bit wr, input logic [2:0] wa, input logic [31:0] wd, input bit dreq);
    bit ack, clr, done, start;
    int b;
    ack = mem_req && (cyc_n % 3 != 1);
    cyc_n++;
    reg_wr_en = wr; reg_wr_addr = wa; reg_wdata = wd; dev_req = dreq; mem_ack = ack;
    clr   = wr && wa == 3'd4 && wd[2];
    done  = m_busy && ack;
    start = !m_busy && m_en && m_valid[m_chan] && !m_stopped && dreq;
    if (done) begin
      b = int'(m_chan);
      if (m_cur[b] == m_end[b]) begin
        m_valid[b] = 0;
        if (m_stop[b]) m_stopped = 1;
        else           m_chan = !m_chan;
      end else begin
        m_cur[b] = m_cur[b] + (AW'(1) << m_sz);
      end
      m_busy = 0;
    end
    if (start) m_busy = 1;
    if (wr) begin
      case (wa)
        3'd0: m_cur[0] = wd[AW-1:0];
        3'd1: begin m_end[0] = wd[AW-1:0]; m_stop[0] = wd[31]; m_valid[0] = 1; end
        3'd2: m_cur[1] = wd[AW-1:0];
        3'd3: begin m_end[1] = wd[AW-1:0]; m_stop[1] = wd[31]; m_valid[1] = 1; end
        3'd4: begin m_en = wd[0]; m_dir = wd[1]; m_sz = wd[4:3]; end
        default: ;
      endcase
    end
    if (clr) begin
      m_valid[0] = 0; m_valid[1] = 0; m_chan = 0; m_stopped = 0; m_busy = 0;
    end
    @(negedge clk);
    compare();
  endtask

  // One quiet cycle, then a register read check at the ports.
  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    cyc(0, 3'd0, 32'd0, 0);
    reg_rd_addr = a;
    #1;
    chk(req, reg_rdata, exp);
    reg_rd_addr = 3'd5;
  endtask

  initial begin
    #(CLK_NS * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_cur[0] = '0; m_cur[1] = '0; m_end[0] = '0; m_end[1] = '0;
    m_stop[0] = 0; m_stop[1] = 0; m_valid[0] = 0; m_valid[1] = 0;
    m_chan = 0; m_busy = 0; m_stopped = 0; m_en = 0; m_dir = 0; m_sz = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 status", reg_rdata, 32'h2);

    // Chain A, B, A' (stop) with 4-byte units, device-to-memory
    cyc(1, 3'd4, 32'h17, 0);
    cyc(1, 3'd4, 32'h13, 0);
    cyc(1, 3'd0, 32'h100, 0);
    cyc(1, 3'd1, 32'h10C, 0);
    rd_chk(3'd1, 32'h10C, "R2 end A readback");
    rd_chk(3'd4, 32'h13, "R2 control readback");
    rd_chk(3'd5, 32'h1, "R11 A valid, B free");
    cyc(1, 3'd2, 32'h200, 0);
    cyc(1, 3'd3, 32'h208, 0);
    rd_chk(3'd5, 32'h0, "R11 both valid");
    for (int i = 0; i < 200 && m_valid[0]; i++) cyc(0, 3'd0, 32'd0, 1);
    cyc(1, 3'd0, 32'h300, 0);
    cyc(1, 3'd1, 32'h8000_0304, 0);
    rd_chk(3'd1, 32'h8000_0304, "R2 stop flag readback");
    rd_chk(3'd0, 32'h300, "R2 current A readback");
    for (int i = 0; i < 200 && !m_stopped; i++) cyc(0, 3'd0, 32'd0, 1);
    repeat (4) cyc(0, 3'd0, 32'd0, 1);
    rd_chk(3'd5, 32'h2, "R6 stopped status");
    cyc(1, 3'd3, 32'h208, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 3'd0, 32'd0, 1);
      chk("R6 no request after stop", 32'(mem_req), 32'd0);
    end
    rd_chk(3'd5, 32'h2, "R6 stays stopped");

    // CLEAR in the middle of a transfer, byte units
    cyc(1, 3'd4, 32'h07, 0);
    cyc(1, 3'd4, 32'h03, 0);
    cyc(1, 3'd0, 32'h400, 0);
    cyc(1, 3'd1, 32'h40F, 0);
    cyc(1, 3'd2, 32'h500, 0);
    cyc(1, 3'd3, 32'h503, 0);
    repeat (7) cyc(0, 3'd0, 32'd0, 1);
    cyc(1, 3'd4, 32'h07, 1);
    chk("R9 request dropped", 32'(mem_req), 32'd0);
    rd_chk(3'd5, 32'h3, "R9 cleared status");

    // Memory-to-device, intermittent device requests, then disable
    cyc(1, 3'd4, 32'h01, 0);
    cyc(1, 3'd0, 32'h400, 0);
    cyc(1, 3'd1, 32'h40F, 0);
    cyc(1, 3'd2, 32'h500, 0);
    cyc(1, 3'd3, 32'h503, 0);
    for (int i = 0; i < 9; i++) cyc(0, 3'd0, 32'd0, i[0]);
    cyc(1, 3'd4, 32'h00, 1);
    repeat (3) cyc(0, 3'd0, 32'd0, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 3'd0, 32'd0, 1);
      chk("R10 no request while disabled", 32'(mem_req), 32'd0);
    end
    rd_chk(3'd5, 32'h2, "R8 disabled shows OVER");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule